// File: doc/BRIEF.md
# Floating-Point to 32-bit Integer Converter

This block converts one IEEE 754 operand, in half, single or double precision, into a 32-bit integer. Rounding is always to the nearest integer, with exact halves going to the even neighbour. No rounding-mode input exists, and the result never carries fractional bits. A select bit chooses between an unsigned result and a two's-complement signed result. The same datapath serves all three input widths. Each precision is unpacked into a common sign, exponent and significand form before alignment and rounding.

Results are registered once, so `valid_o` is `valid_i` delayed by one clock. Two status bits come with each result. The invalid bit reports a NaN, an unsupported format code, or a value that had to be clamped to the integer range. The inexact bit reports that nonzero fraction bits were dropped on an otherwise valid conversion. No other flags are produced.

Top module: `fp2int_cvt`

## Requirements
- R1: `valid_o` equals the `valid_i` of the previous clock. While `rst_ni` is low, `valid_o`, `res_o`, `invalid_o` and `inexact_o` are all 0.
- R2: `fmt_i` selects the input precision. 2'b01 is half precision from `opnd_i[15:0]`, 2'b10 is single precision from `opnd_i[31:0]`, and 2'b11 is double precision from all 64 bits. Bits above the selected width have no effect on the result.
- R3: `fmt_i` = 2'b00 is unsupported. It gives `res_o` = 0 with `invalid_o` = 1.
- R4: Rounding is to the nearest integer, and exact halves go to the even integer. For example, 2.5 gives 2, 3.5 gives 4, 0.5 gives 0 and 1.5 gives 2.
- R5: With `signed_i` = 1 the result is two's complement. Values above 2^31-1 give 0x7FFFFFFF, and values below -2^31 give 0x80000000. Both clamps raise `invalid_o`.
- R6: With `signed_i` = 0, a rounded value above 0xFFFFFFFF gives 0xFFFFFFFF with invalid. A negative input that rounds to -1 or below gives 0 with invalid. A negative input that rounds to zero gives 0 without invalid.
- R7: Any NaN gives 0 with invalid. Positive and negative infinity clamp like out-of-range finite values and raise invalid.
- R8: Zeros of either sign and subnormals give 0. A nonzero subnormal raises inexact.
- R9: `inexact_o` is 1 exactly when dropped fraction bits were nonzero and `invalid_o` is 0. Both status bits are 0 whenever `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| fmt_i | input | 2 | Precision select (01 half, 10 single, 11 double) |
| signed_i | input | 1 | 1 gives a signed result, 0 gives an unsigned result |
| opnd_i | input | 64 | Floating-point operand, right-aligned |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| res_o | output | 32 | Integer result |
| invalid_o | output | 1 | Invalid-operation status |
| inexact_o | output | 1 | Inexact status |

## Verification
On every cycle, the embedded assertions check the following properties:
- the one-cycle valid latency;
- that invalid and inexact are never set together;
- quiet status while no result is valid;
- that a signed invalid result is one of the three permitted clamp values;
- that an unsigned negative input never yields a nonzero result;
- that a NaN always gives zero with invalid.

Other behaviours are shown only by the bench scenarios, which compare against a behavioural reference model:
- whether a tie goes to the even neighbour;
- where the rounding carry pushes a value just below 2^32 over the range;
- that upper operand bits are ignored for the narrow formats;
- the exact boundaries at plus and minus 2^31.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;
  localparam int unsigned OPND_W = 64;
  localparam int unsigned INT_W  = 32;
  localparam int unsigned SIG_W  = 53;
  localparam int unsigned EXP_W  = 13;
  localparam int unsigned N_FMT  = 3;

  typedef enum logic [1:0] {
    FMT_RSVD   = 2'b00,
    FMT_HALF   = 2'b01,
    FMT_SINGLE = 2'b10,
    FMT_DOUBLE = 2'b11
  } fmt_e;

  typedef struct packed {
    logic                    sign;
    logic signed [EXP_W-1:0] exp;
    logic [SIG_W-1:0]        sig;
    logic                    is_nan;
    logic                    is_inf;
    logic                    is_zero;
    logic                    is_sub;
    logic                    bad_fmt;
  } unpacked_t;

  // index 0 half, 1 single, 2 double
  function automatic int unsigned fmt_exp_bits(int unsigned idx);
    case (idx)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int unsigned fmt_man_bits(int unsigned idx);
    case (idx)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction
endpackage

// File: rtl/fp_unpack.sv
module fp_unpack
  import fp2int_pkg::*;
(
  input  logic [OPND_W-1:0] opnd_i,
  input  fmt_e              fmt_i,
  output unpacked_t         unp_o
);
  for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
    localparam int unsigned EW   = fmt_exp_bits(g);
    localparam int unsigned MW   = fmt_man_bits(g);
    localparam int unsigned BIAS = (1 << (EW - 1)) - 1;
    logic [EW-1:0] ef;
    logic [MW-1:0] mf;
    unpacked_t     c;

    assign ef = opnd_i[MW +: EW];
    assign mf = opnd_i[MW-1:0];

    always_comb begin
      c         = '0;
      c.sign    = opnd_i[EW+MW];
      c.exp     = $signed(EXP_W'(ef)) - $signed(EXP_W'(BIAS));
      c.sig     = SIG_W'({1'b1, mf}) << (SIG_W - 1 - MW);
      c.is_nan  = (&ef) & (|mf);
      c.is_inf  = (&ef) & ~(|mf);
      c.is_zero = ~(|ef) & ~(|mf);
      c.is_sub  = ~(|ef) & (|mf);
    end
  end

  always_comb begin
    unp_o = '0;
    unique case (fmt_i)
      FMT_HALF:   unp_o = g_fmt[0].c;
      FMT_SINGLE: unp_o = g_fmt[1].c;
      FMT_DOUBLE: unp_o = g_fmt[2].c;
      default:    unp_o.bad_fmt = 1'b1;
    endcase
  end
endmodule

// File: rtl/fp_round_rne.sv
module fp_round_rne
  import fp2int_pkg::*;
(
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  output logic [INT_W+1:0]        mag_o,
  output logic                    huge_o,
  output logic                    lost_o
);
  localparam int unsigned SH_W = $clog2(SIG_W + 2);
  localparam int unsigned FAR  = SIG_W + 1;  // pushes every bit below the guard

  logic signed [EXP_W-1:0] shs;
  logic [SH_W-1:0]         sh;
  logic [2*SIG_W-1:0]      wide;
  logic [SIG_W-1:0]        ipart, frac;
  logic                    guard, sticky, rnd_up, big_e;

  always_comb begin
    big_e = exp_i > $signed(EXP_W'(INT_W));
    shs   = $signed(EXP_W'(SIG_W - 1)) - exp_i;
    if (exp_i < $signed(-EXP_W'(1)))
      sh = SH_W'(FAR);
    else if (big_e)
      sh = '0;
    else
      sh = shs[SH_W-1:0];
    wide   = {sig_i, {SIG_W{1'b0}}} >> sh;
    ipart  = wide[2*SIG_W-1 -: SIG_W];
    frac   = wide[SIG_W-1:0];
    guard  = frac[SIG_W-1];
    sticky = |frac[SIG_W-2:0];
    rnd_up = guard & (sticky | ipart[0]);
    huge_o = big_e | (|ipart[SIG_W-1:INT_W+1]);
    mag_o  = {1'b0, ipart[INT_W:0]} + (INT_W + 2)'(rnd_up);
    lost_o = guard | sticky;
  end
endmodule

// File: rtl/fp_saturate.sv
module fp_saturate
  import fp2int_pkg::*;
(
  input  logic             sign_i,
  input  logic             nan_i,
  input  logic             inf_i,
  input  logic             zero_i,
  input  logic             sub_i,
  input  logic             bad_i,
  input  logic             signed_i,
  input  logic [INT_W+1:0] mag_i,
  input  logic             huge_i,
  input  logic             lost_i,
  output logic [INT_W-1:0] res_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  localparam logic [INT_W+1:0] POS_LIM = (INT_W + 2)'((64'd1 << (INT_W - 1)) - 64'd1);
  localparam logic [INT_W+1:0] NEG_LIM = (INT_W + 2)'(64'd1 << (INT_W - 1));
  localparam logic [INT_W-1:0] S_MAX   = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] S_MIN   = {1'b1, {(INT_W-1){1'b0}}};

  logic             ovf, tiny;
  logic [INT_W+1:0] mag;
  logic             lost;

  always_comb begin
    ovf       = huge_i | inf_i;
    tiny      = zero_i | sub_i;
    mag       = tiny ? '0 : mag_i;
    lost      = sub_i | (~tiny & ~inf_i & lost_i);
    res_o     = '0;
    invalid_o = 1'b0;
    if (bad_i | nan_i) begin
      invalid_o = 1'b1;
    end else if (signed_i) begin
      if (!sign_i) begin
        if (ovf || mag > POS_LIM) begin
          res_o = S_MAX; invalid_o = 1'b1;
        end else res_o = mag[INT_W-1:0];
      end else begin
        if (ovf || mag > NEG_LIM) begin
          res_o = S_MIN; invalid_o = 1'b1;
        end else res_o = -mag[INT_W-1:0];
      end
    end else begin
      if (sign_i) begin
        invalid_o = ovf | (|mag);
      end else if (ovf || |mag[INT_W+1:INT_W]) begin
        res_o = '1; invalid_o = 1'b1;
      end else res_o = mag[INT_W-1:0];
    end
    inexact_o = lost & ~invalid_o;
  end
endmodule

// File: rtl/fp2int_cvt.sv
module fp2int_cvt
  import fp2int_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        fmt_i,
  input  logic              signed_i,
  input  logic [OPND_W-1:0] opnd_i,
  output logic              valid_o,
  output logic [INT_W-1:0]  res_o,
  output logic              invalid_o,
  output logic              inexact_o
);
  unpacked_t        unp;
  logic [INT_W+1:0] mag;
  logic             huge, lost;
  logic [INT_W-1:0] res_d;
  logic             inv_d, inx_d;

  fp_unpack u_unpack (
    .opnd_i (opnd_i),
    .fmt_i  (fmt_e'(fmt_i)),
    .unp_o  (unp)
  );

  fp_round_rne u_round (
    .exp_i  (unp.exp),
    .sig_i  (unp.sig),
    .mag_o  (mag),
    .huge_o (huge),
    .lost_o (lost)
  );

  fp_saturate u_sat (
    .sign_i    (unp.sign),
    .nan_i     (unp.is_nan),
    .inf_i     (unp.is_inf),
    .zero_i    (unp.is_zero),
    .sub_i     (unp.is_sub),
    .bad_i     (unp.bad_fmt),
    .signed_i  (signed_i),
    .mag_i     (mag),
    .huge_i    (huge),
    .lost_i    (lost),
    .res_o     (res_d),
    .invalid_o (inv_d),
    .inexact_o (inx_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      res_o     <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      invalid_o <= valid_i & inv_d;
      inexact_o <= valid_i & inx_d;
      if (valid_i) res_o <= res_d;
    end
  end

  a_r1_valid_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));
  a_r1_valid_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && $past(rst_ni)) |-> valid_o);
  a_r9_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(invalid_o && inexact_o));
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!invalid_o && !inexact_o));
  a_r5_clamp_vals: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && invalid_o && $past(signed_i)) |->
      (res_o == '0 || res_o == {1'b0, {(INT_W-1){1'b1}}} || res_o == {1'b1, {(INT_W-1){1'b0}}}));
  a_r6_uns_neg_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(!signed_i && unp.sign)) |-> res_o == '0);
  a_r7_nan_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(unp.is_nan)) |-> (res_o == '0 && invalid_o));
endmodule

// File: tb/sim_fp2int_cvt.sv
module sim_fp2int_cvt;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  fmt_i = 2'b00;
  logic        signed_i = 1'b0;
  logic [63:0] opnd_i = '0;
  logic        valid_o, invalid_o, inexact_o;
  logic [31:0] res_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    bit          v;
    logic [31:0] r;
    bit          inv;
    bit          inx;
    string       tag;
  } exp_t;
  exp_t expq[$];

  always #2 clk_i = ~clk_i;

  fp2int_cvt u0 (
    .clk_i, .rst_ni, .valid_i, .fmt_i, .signed_i, .opnd_i,
    .valid_o, .res_o, .invalid_o, .inexact_o
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic void ref_cvt(input logic [1:0] f, input logic [63:0] x, input bit sg,
                                  output logic [31:0] r, output bit inv, output bit inx);
    int ew, mw, bias, e;
    logic [63:0] ef, mf, m, q, rem, half;
    bit s, frac, ovf;
    r = '0; inv = 0; inx = 0; frac = 0; ovf = 0; q = '0;
    case (f)
      2'b01: begin ew = 5;  mw = 10; end
      2'b10: begin ew = 8;  mw = 23; end
      2'b11: begin ew = 11; mw = 52; end
      default: begin inv = 1; return; end
    endcase
    bias = (1 << (ew - 1)) - 1;
    s  = x[ew + mw];
    ef = (x >> mw) & ((64'd1 << ew) - 1);
    mf = x & ((64'd1 << mw) - 1);
    if (ef == (64'd1 << ew) - 1) begin
      if (mf != 0) begin inv = 1; return; end
      ovf = 1;
    end else if (ef == 0) begin
      frac = (mf != 0);
    end else begin
      m = mf | (64'd1 << mw);
      e = int'(ef) - bias;
      if (e > 40) ovf = 1;
      else if (e - mw >= 0) q = m << (e - mw);
      else if (mw - e >= 62) frac = 1;
      else begin
        q    = m >> (mw - e);
        rem  = m - (q << (mw - e));
        half = 64'd1 << (mw - e - 1);
        if (rem > half || (rem == half && q[0])) q = q + 1;
        frac = (rem != 0);
      end
    end
    if (sg) begin
      if (!s && (ovf || q > 64'h7FFF_FFFF)) begin r = 32'h7FFF_FFFF; inv = 1; end
      else if (s && (ovf || q > 64'h8000_0000)) begin r = 32'h8000_0000; inv = 1; end
      else r = s ? 32'(64'd0 - q) : q[31:0];
    end else begin
      if (s) inv = ovf || (q != 0);
      else if (ovf || q > 64'hFFFF_FFFF) begin r = 32'hFFFF_FFFF; inv = 1; end
      else r = q[31:0];
    end
    inx = frac && !inv;
  endfunction

  // compare previous cycle's expectation, then drive the next operand
  task automatic step(bit v, logic [1:0] f, logic [63:0] x, bit sg, string tag);
    exp_t e;
    @(negedge clk_i);
    if (expq.size() > 0) begin
      exp_t o = expq.pop_front();
      chk({o.tag, " valid"}, 32'(valid_o), 32'(o.v));
      if (o.v) begin
        chk({o.tag, " res"}, res_o, o.r);
        chk({o.tag, " invalid"}, 32'(invalid_o), 32'(o.inv));
        chk({o.tag, " inexact"}, 32'(inexact_o), 32'(o.inx));
      end else begin
        chk({o.tag, " R9 idle status"}, {30'd0, invalid_o, inexact_o}, 32'd0);
      end
    end
    valid_i = v; fmt_i = f; opnd_i = x; signed_i = sg;
    e.v = v; e.tag = tag;
    ref_cvt(f, x, sg, e.r, e.inv, e.inx);
    expq.push_back(e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 reset valid", 32'(valid_o), 32'd0);
    chk("R1 reset status", {30'd0, invalid_o, inexact_o}, 32'd0);
    chk("R1 reset res", res_o, 32'd0);
    rst_ni = 1'b1;

    step(1, 2'b11, 64'h4004000000000000, 1, "R4 2.5");
    step(1, 2'b11, 64'h400C000000000000, 1, "R4 3.5");
    step(1, 2'b11, 64'h3FE0000000000000, 0, "R4 0.5");
    step(1, 2'b11, 64'h3FF8000000000000, 0, "R4 1.5");
    step(1, 2'b11, 64'hC004000000000000, 1, "R4 -2.5 signed");
    step(0, 2'b11, 64'h4004000000000000, 1, "R1 idle");
    step(1, 2'b11, 64'h41E0000000000000, 1, "R5 2^31 signed");
    step(1, 2'b11, 64'hC1E0000000000000, 1, "R5 -2^31 signed");
    step(1, 2'b11, 64'hC1E0000000200000, 1, "R5 below -2^31");
    step(1, 2'b11, 64'h41E0000000000000, 0, "R6 2^31 unsigned");
    step(1, 2'b11, 64'h41F0000000000000, 0, "R6 2^32 unsigned");
    step(1, 2'b11, 64'h41EFFFFFFFF00000, 0, "R6 tie carries over range");
    step(1, 2'b11, 64'hBFD0000000000000, 0, "R6 -0.25 unsigned");
    step(1, 2'b11, 64'hBFE0000000000000, 0, "R6 -0.5 unsigned");
    step(1, 2'b11, 64'hBFF0000000000000, 0, "R6 -1.0 unsigned");
    step(1, 2'b11, 64'h7FF8000000000000, 1, "R7 NaN");
    step(1, 2'b10, 64'h000000007FC00001, 0, "R7 single NaN");
    step(1, 2'b11, 64'h7FF0000000000000, 1, "R7 +inf signed");
    step(1, 2'b11, 64'hFFF0000000000000, 1, "R7 -inf signed");
    step(1, 2'b11, 64'hFFF0000000000000, 0, "R7 -inf unsigned");
    step(1, 2'b11, 64'h0000000000000001, 1, "R8 subnormal");
    step(1, 2'b11, 64'h8000000000000000, 1, "R8 -0");
    step(1, 2'b01, 64'h0000000000000000, 0, "R8 half +0");
    step(1, 2'b10, 64'hDEADBEEF40200000, 1, "R2 single 2.5 upper junk");
    step(1, 2'b10, 64'h12345678BFC00000, 1, "R2 single -1.5");
    step(1, 2'b01, 64'hFFFFFFFFFFFF4100, 0, "R2 half 2.5 upper junk");
    step(1, 2'b01, 64'h0000000000007C00, 0, "R2 half inf");
    step(1, 2'b01, 64'hABCD000000007BFF, 1, "R2 half max");
    step(1, 2'b00, 64'h3FF0000000000000, 1, "R3 reserved fmt");

    for (int i = 0; i < 300; i++) begin
      logic [63:0] x;
      logic [1:0]  f;
      f = 2'(1 + (i % 3));
      x = {$urandom, $urandom};
      if (f == 2'b11) x[62:52] = 11'(1000 + ($urandom % 60));
      else if (f == 2'b10) x[30:23] = 8'(110 + ($urandom % 50));
      step(1, f, x, 1'($urandom), "R4 random");
    end
    step(0, 2'b00, '0, 0, "R1 drain");
    step(0, 2'b00, '0, 0, "R1 drain");
    finish_run();
  end
endmodule